// File: doc/BRIEF.md
# Presettable Synchronous Decade Counter Digit

A one-digit decimal counter that holds four state bits and updates them all together on the rising clock edge. Software or surrounding logic can zero the digit or preset it to a value from four data inputs. Both of these actions happen on the next edge and take effect whatever the enables are doing. Counting needs two enables. One is a plain count permit. The other is a carry-chain enable, and it also gates the carry output.

The carry output is combinational. It rises while the digit holds nine and the chain enable is high. To build a synchronous multi-digit counter, wire each digit's carry into the chain enable of the next digit up. The digits share one clock and need no extra gating. Codes ten to fifteen are not part of the decimal sequence. They can appear after a preset or in a corrupted state, and when counting is enabled the digit steers them back into zero to nine within two counts.

Top module: `decade_counter`

## Requirements
- R1: While `rst_ni` is low the count is 0 and the carry is low, independent of the clock.
- R2: When `clr_ni` is low at a rising edge, the count becomes 0 on that edge, whatever `load_ni`, `enp_i` and `ent_i` are. Clear takes priority over load.
- R3: When `clr_ni` is high and `load_ni` is low at a rising edge, the count takes `data_i` on that edge, whatever the enables are. Bit 0 is the least significant bit. Any of the 16 codes can be loaded.
- R4: With clear and load inactive, the count advances by one only when `enp_i` and `ent_i` are both high. Otherwise it holds, and that includes codes 10 to 15. Input changes between edges do not alter the count.
- R5: Counting from a legal code runs 0,1,…,9 and then wraps to 0.
- R6: `rco_o` is high exactly when the count is 9 and `ent_i` is high. It follows `ent_i` with no clock edge.
- R7: An enabled count from an illegal code follows 10→11→6, 12→13→4 and 14→15→2. Every illegal code therefore reaches a legal one within two counts.
- R8: Two digits, with the lower digit's `rco_o` driving the upper digit's `ent_i`, count 00 to 99 and wrap to 00. The upper digit's carry is high only at 99.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset to 0, active low |
| clr_ni | input | 1 | Synchronous clear, active low |
| load_ni | input | 1 | Synchronous parallel load, active low |
| enp_i | input | 1 | Count permit |
| ent_i | input | 1 | Chain enable; also gates the carry |
| data_i | input | 4 | Preset value, bit 0 is the least significant bit |
| q_o | output | 4 | Current count, bit 0 is the least significant bit |
| rco_o | output | 1 | Ripple carry, high at count 9 with `ent_i` high |

## Verification
The state is the output, so a wrong next-state decision shows on `q_o` one edge after the faulty cycle. A wrong terminal decode or a wrong carry gate shows on `rco_o` at once, without a clock. Any fault in the wrap or recovery path appears within two enabled counts. In a two-digit chain, a carry fault shows as a skipped or repeated tens value within ten counts.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2,
    MODE_CLEAR = 2'd3
  } mode_e;
endpackage

// File: rtl/dc_mode_dec.sv
module dc_mode_dec
  import dc_pkg::*;
(
  input  logic  clr_ni,
  input  logic  load_ni,
  input  logic  enp_i,
  input  logic  ent_i,
  output mode_e mode_o
);
  // priority: clear > load > count > hold
  always_comb begin
    if (!clr_ni)             mode_o = MODE_CLEAR;
    else if (!load_ni)       mode_o = MODE_LOAD;
    else if (enp_i && ent_i) mode_o = MODE_COUNT;
    else                     mode_o = MODE_HOLD;
  end
endmodule

// File: rtl/dc_step.sv
module dc_step #(
  parameter int W   = 4,
  parameter int MOD = 10
) (
  input  logic [W-1:0] q_i,
  output logic [W-1:0] inc_o
);
  localparam logic [W-1:0] LAST   = W'(MOD - 1);
  localparam logic [W-1:0] MODV   = W'(MOD);
  localparam logic [W:0]   MIRROR = (W+1)'((1 << W) + 1);

  logic [W:0]   mirrored;
  logic [W-1:0] odd_exit;

  assign mirrored = MIRROR - {1'b0, q_i};
  // odd illegal codes jump back down; clamp keeps any other modulus legal
  assign odd_exit = (mirrored[W-1:0] >= MODV) ? '0 : mirrored[W-1:0];

  always_comb begin
    if (q_i == LAST)      inc_o = '0;
    else if (q_i < MODV)  inc_o = q_i + 1'b1;
    else if (!q_i[0])     inc_o = q_i + 1'b1;
    else                  inc_o = odd_exit;
  end
endmodule

// File: rtl/dc_carry.sv
module dc_carry #(
  parameter int W   = 4,
  parameter int MOD = 10
) (
  input  logic [W-1:0] q_i,
  input  logic         ent_i,
  output logic         rco_o
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);
  assign rco_o = ent_i & (q_i == LAST);
endmodule

// File: rtl/decade_counter.sv
module decade_counter #(
  parameter int W   = 4,
  parameter int MOD = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_ni,
  input  logic         load_ni,
  input  logic         enp_i,
  input  logic         ent_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o,
  output logic         rco_o
);
  import dc_pkg::*;

  mode_e        mode;
  logic [W-1:0] cnt_q, cnt_d, inc;

  dc_mode_dec u_mode (
    .clr_ni (clr_ni),
    .load_ni(load_ni),
    .enp_i  (enp_i),
    .ent_i  (ent_i),
    .mode_o (mode)
  );

  dc_step #(.W(W), .MOD(MOD)) u_step (
    .q_i  (cnt_q),
    .inc_o(inc)
  );

  dc_carry #(.W(W), .MOD(MOD)) u_carry (
    .q_i  (cnt_q),
    .ent_i(ent_i),
    .rco_o(rco_o)
  );

  always_comb begin
    unique case (mode)
      MODE_CLEAR: cnt_d = '0;
      MODE_LOAD:  cnt_d = data_i;
      MODE_COUNT: cnt_d = inc;
      default:    cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign q_o = cnt_q;
endmodule

// File: rtl/dc_checker.sv
module dc_checker #(
  parameter int W   = 4,
  parameter int MOD = 10
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         clr_ni,
  input logic         load_ni,
  input logic         enp_i,
  input logic         ent_i,
  input logic [W-1:0] data_i,
  input logic [W-1:0] q_o,
  input logic         rco_o
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);
  localparam logic [W-1:0] MODV = W'(MOD);

  logic counting;
  assign counting = clr_ni && load_ni && enp_i && ent_i;

  always_comb begin
    if (!rst_ni) AST_RESET_ZERO: assert (q_o == '0 && !rco_o); // R1
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> q_o == '0); // R2

  AST_LOAD_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !load_ni) |=> q_o == $past(data_i)); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && load_ni && !(enp_i && ent_i)) |=> $stable(q_o)); // R4

  AST_WRAP_NINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (counting && q_o == LAST) |=> q_o == '0); // R5

  AST_CARRY_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rco_o |-> (ent_i && q_o == LAST)); // R6

  AST_RECOVER_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (counting && q_o >= MODV && q_o[0]) |=> q_o < MODV); // R7

  AST_RECOVER_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (counting && q_o >= MODV && !q_o[0]) |=> (q_o >= MODV && q_o[0])); // R7
endmodule

bind decade_counter dc_checker #(.W(W), .MOD(MOD)) u_chk (.*);

// File: tb/tb_decade_counter.sv
module tb_decade_counter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic       clr_n = 1, load_n = 1, enp = 0, ent = 0;
  logic [3:0] data = 0;
  logic [3:0] q, q_hi;
  logic       rco, rco_hi;
  int         n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  decade_counter dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .load_ni(load_n),
    .enp_i(enp), .ent_i(ent), .data_i(data), .q_o(q), .rco_o(rco)
  );

  decade_counter dut_hi (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .load_ni(load_n),
    .enp_i(enp), .ent_i(rco), .data_i(data), .q_o(q_hi), .rco_o(rco_hi)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    #3;
    check("R1 q in reset", q, 0);
    check("R1 rco in reset", rco, 0);
    rst_n = 1;
    #1;
    check("R1 q after release", q, 0);
  endtask

  task automatic t_sequence();
    // clear (enables high, load also low: clear wins)
    enp = 1; ent = 1; data = 4'd5; load_n = 0; clr_n = 0;
    tick();
    check("R2 clear over load", q, 0);
    clr_n = 1; data = 4'd7; enp = 0; ent = 0;
    tick();
    check("R3 preset 7", q, 7);
    load_n = 1; enp = 1; ent = 1;
    for (int i = 1; i <= 6; i++) begin
      tick();
      check("R5 count", q, (7 + i) % 10);
      check("R6 rco only at 9", rco, ((7 + i) % 10 == 9) ? 1 : 0);
    end
    enp = 0;
    tick();
    check("R4 hold enp low", q, 3);
    enp = 1; ent = 0;
    tick();
    check("R4 hold ent low", q, 3);
    // glitch on controls between edges must not change state
    ent = 1; load_n = 0; #1; load_n = 1; clr_n = 0; #1; clr_n = 1; ent = 0;
    #1;
    check("R4 no change between edges", q, 3);
  endtask

  task automatic t_carry_gate();
    clr_n = 1; load_n = 0; data = 4'd9;
    tick();
    load_n = 1; ent = 1; enp = 0;
    #1;
    check("R6 rco at 9 ent high", rco, 1);
    ent = 0;
    #1;
    check("R6 rco follows ent low", rco, 0);
    ent = 1; enp = 1;
    tick();
    check("R5 wrap 9 to 0", q, 0);
    check("R6 rco low at 0", rco, 0);
  endtask

  task automatic t_recover();
    int start [3] = '{10, 12, 14};
    int mid   [3] = '{11, 13, 15};
    int fin   [3] = '{6, 4, 2};
    for (int k = 0; k < 3; k++) begin
      enp = 0; ent = 1; load_n = 0; data = 4'(start[k]);
      tick();
      check("R3 load illegal", q, start[k]);
      load_n = 1;
      tick();
      check("R4 illegal holds when idle", q, start[k]);
      enp = 1;
      tick();
      check("R7 first step", q, mid[k]);
      tick();
      check("R7 second step", q, fin[k]);
    end
    enp = 0; load_n = 0; data = 4'd15;
    tick();
    load_n = 1; enp = 1;
    tick();
    check("R7 15 to 2", q, 2);
  endtask

  task automatic t_cascade();
    enp = 0; ent = 0; clr_n = 0;
    tick();
    clr_n = 1;
    check("R8 cleared pair", q_hi * 10 + q, 0);
    enp = 1; ent = 1;
    for (int i = 1; i <= 100; i++) begin
      tick();
      check("R8 chain value", q_hi * 10 + q, i % 100);
      check("R8 upper carry", rco_hi, (i % 100 == 99) ? 1 : 0);
    end
    enp = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_sequence();
    t_carry_gate();
    t_recover();
    t_cascade();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule